// File: doc/BRIEF.md
# Interrupt Controller Programming and Acknowledge Logic

This block is the software-facing half of an eight-line interrupt controller. A byte-wide register port with one address bit takes the initialization words and the run-time commands, and it serves the register readback. Behind the port sit the in-service register, the mask register, the rotation base that sets which line ranks first, the vector base and the mode flags. All of these are updated here, whether the host writes to the port or an interrupt is acknowledged.

A separate priority resolver outside this block looks at the pending requests, the mask, the in-service bits and the rotation base. It returns a winner flag and a line number. This block turns that winner into an interrupt vector. A hardware acknowledge with no winner produces the vector of line 7 as a spurious interrupt. This block also reports each real acknowledge on `ackFire`/`ackLine`, so that the request logic can retire edge-triggered requests. In poll mode, software can read the winner and acknowledge it in one read.

Top module: `picRegIf`

## Requirements
- R1: After reset the in-service register, the mask and the rotation base are 0, the vector base is 0 and address 0 reads return the request input `irqReq`.
- R2: A write to address 0 with bit 4 set clears the in-service register, the mask, the rotation base, the vector base, the poll, read-select, special-mask, nested, auto-EOI and rotate-on-auto-EOI flags. It records bit 0 (a mode word will follow) and bit 1 (single, not cascaded) and expects the base word next.
- R3: The base word (address 1) stores the value with bits 2:0 forced to 0. It then moves to the cascade word (cascaded), to the mode word (single with mode word) or to normal operation (single without mode word). The cascade word is discarded and moves to the mode word, or to normal operation if no mode word was announced.
- R4: In the mode word, bit 4 sets the nested flag (`nestedMode`) and bit 1 sets auto-EOI, and the sequence returns to normal operation.
- R5: In normal operation an address-1 write loads the mask. An address-1 read outside poll returns the mask. The mask changes only on writes.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 = 1 arms poll. If bit 1 = 1, bit 0 selects the address-0 read source (1 = in-service, 0 = requests). If bit 6 = 1, bit 5 loads `specialMask`.
- R7: Other address-0 writes decode bits 7:5. Code 1 clears the in-service bit of highest priority, where the priority order starts at the rotation-base line and rises modulo 8. Code 5 does the same and also sets the rotation base to that line + 1. With the in-service register empty, neither code has any effect.
- R8: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the rotation base to that line + 1 (mod 8). Code 6 sets the rotation base to bits 2:0 + 1 (mod 8). Code 2 changes nothing.
- R9: Code 4 sets and code 0 clears rotate-on-auto-EOI. With both auto-EOI and this flag set, an acknowledge sets the rotation base to the acknowledged line + 1.
- R10: An acknowledge of a winning line pulses `ackFire` with `ackLine` equal to the winner. Without auto-EOI it sets that line's in-service bit. With auto-EOI it sets no in-service bit.
- R11: With poll armed, a read returns 8'h80 | line and acknowledges that line, or returns 0 if there is no winner. The read then disarms poll.
- R12: `vector` is the vector base plus `winLine`, or the vector base plus 7 when `winValid` is 0. A hardware acknowledge without a winner changes no state and does not pulse `ackFire`.
- R13: Only one action takes effect per cycle, chosen in the order write, then poll read, then hardware acknowledge. A lower-ranked action in the same cycle is dropped, so a line is acknowledged at most once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 1 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| irqReq | input | 8 | Pending request register from the request logic |
| winValid | input | 1 | Resolver has a winning line |
| winLine | input | 3 | Winning line number |
| intAck | input | 1 | Hardware interrupt acknowledge |
| vector | output | 8 | Interrupt vector for the current winner |
| ackFire | output | 1 | A line is acknowledged this cycle |
| ackLine | output | 3 | Line being acknowledged |
| inService | output | 8 | In-service register |
| maskOut | output | 8 | Mask register |
| rotBase | output | 3 | Line that ranks first in priority |
| specialMask | output | 1 | Special-mask flag |
| nestedMode | output | 1 | Nested-mode flag from the mode word |

## Verification
Some rules are checked on every cycle: the mask and the upper vector bits change only on writes; the rotation base never moves without a write or an acknowledge; the in-service register gains no bit except the one being acknowledged; and an acknowledge is never reported in a write cycle and always names the resolver's winner. Other behaviour can only be shown by the scenarios: how the initialization sequence branches, which command codes clear which bit under a rotated priority order, the wrap of the rotation base, the poll-read encoding, and which action wins when several collide in the same cycle.

// File: rtl/picRegPkg.sv
package picRegPkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    STEP_NORM = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } initStep_t;

  typedef struct packed {
    logic              clrAll;
    logic              ldBase;
    logic              ldMask;
    logic              nsEoi;
    logic              nsRot;
    logic              spEoi;
    logic              setRot;
    logic              ack;
    logic              ackSetIsr;
    logic              ackRot;
    logic [LINE_W-1:0] cmdLine;
    logic [LINE_W-1:0] ackLine;
    logic [DATA_W-1:0] data;
  } strobe_t;

  // Highest-priority set bit, scanning upward from the rotation base.
  // Returns {found, line}.
  function automatic logic [LINE_W:0] topInService(
    input logic [LINES-1:0]  bits,
    input logic [LINE_W-1:0] base
  );
    logic              found;
    logic [LINE_W-1:0] line;
    logic [LINE_W-1:0] idx;
    found = 1'b0;
    line  = '0;
    for (int k = 0; k < LINES; k++) begin
      idx = base + LINE_W'(k);
      if (!found && bits[idx]) begin
        found = 1'b1;
        line  = idx;
      end
    end
    return {found, line};
  endfunction
endpackage

// File: rtl/picRegCtrl.sv
module picRegCtrl
  import picRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intAck,
  input  logic              winValid,
  input  logic [LINE_W-1:0] winLine,
  output strobe_t           stb,
  output logic              pollArmed,
  output logic              readIsr,
  output logic              specialMask,
  output logic              nestedMode
);
  initStep_t stepQ;
  logic      wantMode;
  logic      singleMode;
  logic      autoEoi;
  logic      rotOnAeoi;

  logic       wr0, wr1, isInit, isMode, isCmd;
  logic [2:0] cmd;
  logic       pollRead, hwAck;

  always_comb begin
    wr0      = wrEn && !addr;
    wr1      = wrEn && addr;
    isInit   = wr0 && wrData[4];
    isMode   = wr0 && !wrData[4] && wrData[3];
    isCmd    = wr0 && !wrData[4] && !wrData[3];
    cmd      = wrData[7:5];
    pollRead = rdEn && pollArmed && !wrEn;
    hwAck    = intAck && winValid && !wrEn && !pollRead;
  end

  always_comb begin
    stb           = '0;
    stb.data      = wrData;
    stb.cmdLine   = wrData[LINE_W-1:0];
    stb.ackLine   = winLine;
    stb.clrAll    = isInit;
    stb.ldBase    = wr1 && (stepQ == STEP_BASE);
    stb.ldMask    = wr1 && (stepQ == STEP_NORM);
    stb.nsEoi     = isCmd && (cmd == 3'd1 || cmd == 3'd5);
    stb.nsRot     = cmd == 3'd5;
    stb.spEoi     = isCmd && (cmd == 3'd3 || cmd == 3'd7);
    stb.setRot    = isCmd && (cmd == 3'd6 || cmd == 3'd7);
    stb.ack       = (pollRead && winValid) || hwAck;
    stb.ackSetIsr = !autoEoi;
    stb.ackRot    = autoEoi && rotOnAeoi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ       <= STEP_NORM;
      wantMode    <= 1'b0;
      singleMode  <= 1'b0;
      autoEoi     <= 1'b0;
      rotOnAeoi   <= 1'b0;
      pollArmed   <= 1'b0;
      readIsr     <= 1'b0;
      specialMask <= 1'b0;
      nestedMode  <= 1'b0;
    end else if (isInit) begin
      stepQ       <= STEP_BASE;
      wantMode    <= wrData[0];
      singleMode  <= wrData[1];
      autoEoi     <= 1'b0;
      rotOnAeoi   <= 1'b0;
      pollArmed   <= 1'b0;
      readIsr     <= 1'b0;
      specialMask <= 1'b0;
      nestedMode  <= 1'b0;
    end else begin
      if (wr1) begin
        unique case (stepQ)
          STEP_BASE: stepQ <= singleMode ? (wantMode ? STEP_MODE : STEP_NORM) : STEP_CASC;
          STEP_CASC: stepQ <= wantMode ? STEP_MODE : STEP_NORM;
          STEP_MODE: begin
            nestedMode <= wrData[4];
            autoEoi    <= wrData[1];
            stepQ      <= STEP_NORM;
          end
          default:   stepQ <= STEP_NORM;
        endcase
      end
      if (isMode) begin
        if (wrData[2]) pollArmed   <= 1'b1;
        if (wrData[1]) readIsr     <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
      if (isCmd && (cmd == 3'd0 || cmd == 3'd4)) rotOnAeoi <= cmd[2];
      if (pollRead) pollArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/picRegDatapath.sv
module picRegDatapath
  import picRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              addr,
  input  logic              pollArmed,
  input  logic              readIsr,
  input  logic [LINES-1:0]  irqReq,
  input  logic              winValid,
  input  logic [LINE_W-1:0] winLine,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vector,
  output logic [LINES-1:0]  isrQ,
  output logic [LINES-1:0]  imrQ,
  output logic [LINE_W-1:0] rotQ
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(LINES - 1);

  logic [DATA_W-1:0] baseQ, baseNxt;
  logic [LINES-1:0]  isrNxt, imrNxt;
  logic [LINE_W-1:0] rotNxt;
  logic              hpFound;
  logic [LINE_W-1:0] hpLine;

  always_comb begin
    {hpFound, hpLine} = topInService(isrQ, rotQ);
    isrNxt  = isrQ;
    imrNxt  = imrQ;
    rotNxt  = rotQ;
    baseNxt = baseQ;
    if (stb.clrAll) begin
      isrNxt  = '0;
      imrNxt  = '0;
      rotNxt  = '0;
      baseNxt = '0;
    end else begin
      if (stb.ldBase) baseNxt = stb.data & ~LOW_MASK;
      if (stb.ldMask) imrNxt = stb.data[LINES-1:0];
      if (stb.nsEoi && hpFound) begin
        isrNxt[hpLine] = 1'b0;
        if (stb.nsRot) rotNxt = hpLine + LINE_W'(1);
      end
      if (stb.spEoi)  isrNxt[stb.cmdLine] = 1'b0;
      if (stb.setRot) rotNxt = stb.cmdLine + LINE_W'(1);
      if (stb.ack) begin
        if (stb.ackSetIsr) isrNxt[stb.ackLine] = 1'b1;
        if (stb.ackRot)    rotNxt = stb.ackLine + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isrQ  <= '0;
      imrQ  <= '0;
      rotQ  <= '0;
      baseQ <= '0;
    end else begin
      isrQ  <= isrNxt;
      imrQ  <= imrNxt;
      rotQ  <= rotNxt;
      baseQ <= baseNxt;
    end
  end

  always_comb begin
    if (pollArmed) begin
      rdData = winValid ? {1'b1, {(DATA_W-1-LINE_W){1'b0}}, winLine} : '0;
    end else if (addr) begin
      rdData = DATA_W'(imrQ);
    end else begin
      rdData = readIsr ? DATA_W'(isrQ) : DATA_W'(irqReq);
    end
    vector = baseQ | DATA_W'(winValid ? winLine : LINE_W'(LINES - 1));
  end
endmodule

// File: rtl/picRegIf.sv
module picRegIf
  import picRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LINES-1:0]  irqReq,
  input  logic              winValid,
  input  logic [LINE_W-1:0] winLine,
  input  logic              intAck,
  output logic [DATA_W-1:0] vector,
  output logic              ackFire,
  output logic [LINE_W-1:0] ackLine,
  output logic [LINES-1:0]  inService,
  output logic [LINES-1:0]  maskOut,
  output logic [LINE_W-1:0] rotBase,
  output logic              specialMask,
  output logic              nestedMode
);
  strobe_t stb;
  logic    pollArmed;
  logic    readIsr;

  picRegCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .addr        (addr),
    .wrData      (wrData),
    .intAck      (intAck),
    .winValid    (winValid),
    .winLine     (winLine),
    .stb         (stb),
    .pollArmed   (pollArmed),
    .readIsr     (readIsr),
    .specialMask (specialMask),
    .nestedMode  (nestedMode)
  );

  picRegDatapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (addr),
    .pollArmed (pollArmed),
    .readIsr   (readIsr),
    .irqReq    (irqReq),
    .winValid  (winValid),
    .winLine   (winLine),
    .rdData    (rdData),
    .vector    (vector),
    .isrQ      (inService),
    .imrQ      (maskOut),
    .rotQ      (rotBase)
  );

  assign ackFire = stb.ack;
  assign ackLine = stb.ackLine;
endmodule

// File: rtl/picRegIfChk.sv
module picRegIfChk
  import picRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              winValid,
  input logic [LINE_W-1:0] winLine,
  input logic [DATA_W-1:0] vector,
  input logic              ackFire,
  input logic [LINE_W-1:0] ackLine,
  input logic [LINES-1:0]  inService,
  input logic [LINES-1:0]  maskOut,
  input logic [LINE_W-1:0] rotBase
);
  // R5: mask only moves on a register write
  a_r5_mask_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(maskOut));

  // R8: rotation base moves only on a write or an acknowledge
  a_r8_rot_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !ackFire) |=> $stable(rotBase));

  // R7: in-service gains no bit without an acknowledge
  a_r7_isr_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    !ackFire |=> ((inService & ~$past(inService)) == '0));

  // R10: an acknowledge sets at most the acknowledged line
  a_r10_isr_only_acked: assert property (@(posedge clk) disable iff (!rstN)
    ackFire |=> ((inService & ~$past(inService) & ~(LINES'(1) << $past(ackLine))) == '0));

  // R13: a write cycle never carries an acknowledge
  a_r13_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    ackFire |-> !wrEn);

  // R13: an acknowledge always names the resolver winner
  a_r13_ack_winner: assert property (@(posedge clk) disable iff (!rstN)
    ackFire |-> (winValid && ackLine == winLine));

  // R12: vector base bits change only through writes
  a_r12_base_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(vector[DATA_W-1:LINE_W]));
endmodule

bind picRegIf picRegIfChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .winValid  (winValid),
  .winLine   (winLine),
  .vector    (vector),
  .ackFire   (ackFire),
  .ackLine   (ackLine),
  .inService (inService),
  .maskOut   (maskOut),
  .rotBase   (rotBase)
);

// File: tb/tb_picRegIf.sv
`timescale 1ns/1ps
module tb_picRegIf;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] irqReq = 8'h5A;
  logic       winValid = 1'b0;
  logic [2:0] winLine = '0;
  logic       intAck = 1'b0;
  logic [7:0] vector;
  logic       ackFire;
  logic [2:0] ackLine;
  logic [7:0] inService, maskOut;
  logic [2:0] rotBase;
  logic       specialMask, nestedMode;

  always #2.5 clk = ~clk;

  picRegIf dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq),
    .winValid(winValid), .winLine(winLine), .intAck(intAck),
    .vector(vector), .ackFire(ackFire), .ackLine(ackLine),
    .inService(inService), .maskOut(maskOut), .rotBase(rotBase),
    .specialMask(specialMask), .nestedMode(nestedMode)
  );

  localparam int S_RD = 0, S_VEC = 1, S_ISR = 2, S_MASK = 3, S_ROT = 4,
                 S_ACKF = 5, S_ACKL = 6, S_SMM = 7, S_NEST = 8;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t queueQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic logic [7:0] outOf(int sel);
    case (sel)
      S_RD:    return rdData;
      S_VEC:   return vector;
      S_ISR:   return inService;
      S_MASK:  return maskOut;
      S_ROT:   return {5'd0, rotBase};
      S_ACKF:  return {7'd0, ackFire};
      S_ACKL:  return {5'd0, ackLine};
      S_SMM:   return {7'd0, specialMask};
      default: return {7'd0, nestedMode};
    endcase
  endfunction

  // monitor: drains expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (queueQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = queueQ.pop_front();
        act = outOf(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expectOut(int sel, logic [7:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    queueQ.push_back(it);
  endtask

  task automatic doWrite(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic a, logic [7:0] exp, string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expectOut(S_RD, exp, req);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doAck(logic v, logic [2:0] l, logic [7:0] expVec, string req);
    @(negedge clk);
    winValid = v; winLine = l; intAck = 1'b1;
    expectOut(S_VEC, expVec, req);
    expectOut(S_ACKF, {7'd0, v}, req);
    @(negedge clk);
    intAck = 1'b0; winValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expectOut(S_ISR, 8'h00, "R1 isr");
    expectOut(S_MASK, 8'h00, "R1 mask");
    expectOut(S_ROT, 8'h00, "R1 rot");
    expectOut(S_ACKF, 8'h00, "R1 ackFire");
    expectOut(S_VEC, 8'h07, "R1 vector base");
    rstN = 1'b1;
    doRead(1'b0, 8'h5A, "R1 addr0 reads requests");

    // R5 mask load and readback
    doWrite(1'b1, 8'hA5);
    expectOut(S_MASK, 8'hA5, "R5 mask load");
    doRead(1'b1, 8'hA5, "R5 mask readback");

    // R3 single mode without mode word: base then normal
    doWrite(1'b0, 8'h12);
    expectOut(S_MASK, 8'h00, "R2 init clears mask");
    doWrite(1'b1, 8'h08);
    doWrite(1'b1, 8'h77);
    expectOut(S_MASK, 8'h77, "R3 single no mode word -> normal");

    // single with mode word, auto-EOI
    doWrite(1'b0, 8'h13);
    expectOut(S_MASK, 8'h00, "R2 init clears mask again");
    doWrite(1'b1, 8'h4D);
    doWrite(1'b1, 8'h02);
    expectOut(S_NEST, 8'h00, "R4 nested off");
    doWrite(1'b1, 8'h0F);
    expectOut(S_MASK, 8'h0F, "R3 mode word then normal");
    winValid = 1'b1; winLine = 3'd3;
    expectOut(S_VEC, 8'h4B, "R3 R12 base low bits cleared");
    doAck(1'b1, 3'd3, 8'h4B, "R10 auto-EOI ack");
    expectOut(S_ISR, 8'h00, "R10 auto-EOI leaves isr clear");
    expectOut(S_ROT, 8'h00, "R9 no rotate when flag off");
    doWrite(1'b0, 8'h80);
    doAck(1'b1, 3'd5, 8'h4D, "R9 ack line5");
    expectOut(S_ROT, 8'h06, "R9 rotate on auto-EOI");
    doWrite(1'b0, 8'h00);
    doAck(1'b1, 3'd1, 8'h49, "R9 ack line1");
    expectOut(S_ROT, 8'h06, "R9 rotate flag cleared");

    // cascaded with mode word
    doWrite(1'b0, 8'h11);
    expectOut(S_ROT, 8'h00, "R2 init clears rotation");
    doWrite(1'b1, 8'h20);
    doWrite(1'b1, 8'hFF);
    expectOut(S_MASK, 8'h00, "R3 cascade word ignored");
    doWrite(1'b1, 8'h10);
    expectOut(S_NEST, 8'h01, "R4 nested set");
    doWrite(1'b1, 8'h30);
    expectOut(S_MASK, 8'h30, "R3 cascade path returns to normal");
    doAck(1'b1, 3'd2, 8'h22, "R10 ack line2");
    doAck(1'b1, 3'd6, 8'h26, "R12 vector line6");
    doAck(1'b1, 3'd0, 8'h20, "R10 ack line0");
    expectOut(S_ISR, 8'h45, "R10 isr set without auto-EOI");

    // R6 read select and special mask
    doWrite(1'b0, 8'h0B);
    doRead(1'b0, 8'h45, "R6 addr0 reads in-service");
    doWrite(1'b0, 8'h0A);
    doRead(1'b0, 8'h5A, "R6 addr0 reads requests");
    doWrite(1'b0, 8'h68);
    expectOut(S_SMM, 8'h01, "R6 special mask set");
    doWrite(1'b0, 8'h28);
    expectOut(S_SMM, 8'h01, "R6 special mask kept without bit6");
    doWrite(1'b0, 8'h48);
    expectOut(S_SMM, 8'h00, "R6 special mask cleared");

    // R7 non-specific EOI
    doWrite(1'b0, 8'h20);
    expectOut(S_ISR, 8'h44, "R7 nonspecific clears line0");
    doWrite(1'b0, 8'hA0);
    expectOut(S_ISR, 8'h40, "R7 rotating EOI clears line2");
    expectOut(S_ROT, 8'h03, "R7 rotation base line+1");
    doAck(1'b1, 3'd1, 8'h21, "R10 ack line1");
    doWrite(1'b0, 8'h20);
    expectOut(S_ISR, 8'h02, "R7 rotated order picks line6");

    // R8 specific commands
    doWrite(1'b0, 8'h61);
    expectOut(S_ISR, 8'h00, "R8 specific clears line1");
    doAck(1'b1, 3'd4, 8'h24, "R10 ack line4");
    doAck(1'b1, 3'd7, 8'h27, "R10 ack line7");
    doWrite(1'b0, 8'hE7);
    expectOut(S_ISR, 8'h10, "R8 specific rotate clears line7");
    expectOut(S_ROT, 8'h00, "R8 rotation wraps to 0");
    doWrite(1'b0, 8'hC4);
    expectOut(S_ROT, 8'h05, "R8 set priority");
    expectOut(S_ISR, 8'h10, "R8 set priority keeps isr");
    doWrite(1'b0, 8'h47);
    expectOut(S_ISR, 8'h10, "R8 code2 no isr change");
    expectOut(S_ROT, 8'h05, "R8 code2 no rot change");
    expectOut(S_MASK, 8'h30, "R8 code2 no mask change");
    doWrite(1'b0, 8'h64);
    doWrite(1'b0, 8'hA0);
    expectOut(S_ROT, 8'h05, "R7 empty isr no rotation");
    expectOut(S_ISR, 8'h00, "R7 empty isr stays empty");

    // R11 poll
    doWrite(1'b0, 8'h0C);
    winValid = 1'b1; winLine = 3'd3;
    @(negedge clk);
    rdEn = 1'b1; addr = 1'b1;
    expectOut(S_RD, 8'h83, "R11 poll returns line");
    expectOut(S_ACKF, 8'h01, "R11 poll acknowledges");
    expectOut(S_ACKL, 8'h03, "R11 poll ack line");
    @(negedge clk);
    rdEn = 1'b0; winValid = 1'b0;
    expectOut(S_ISR, 8'h08, "R11 poll sets isr");
    doRead(1'b1, 8'h30, "R11 poll disarmed");
    doWrite(1'b0, 8'h0C);
    doRead(1'b1, 8'h00, "R11 poll with nothing pending");
    expectOut(S_ISR, 8'h08, "R11 empty poll keeps isr");
    doRead(1'b1, 8'h30, "R11 empty poll disarms");

    // R12 spurious acknowledge
    doAck(1'b0, 3'd2, 8'h27, "R12 spurious vector");
    expectOut(S_ISR, 8'h08, "R12 spurious keeps isr");

    // R13 collisions
    @(negedge clk);
    wrEn = 1'b1; addr = 1'b1; wrData = 8'h3C;
    winValid = 1'b1; winLine = 3'd1; intAck = 1'b1;
    expectOut(S_ACKF, 8'h00, "R13 write drops ack");
    @(negedge clk);
    wrEn = 1'b0; intAck = 1'b0; winValid = 1'b0;
    expectOut(S_MASK, 8'h3C, "R13 write applied");
    expectOut(S_ISR, 8'h08, "R13 dropped ack leaves isr");
    doWrite(1'b0, 8'h0C);
    @(negedge clk);
    rdEn = 1'b1; addr = 1'b0; intAck = 1'b1;
    winValid = 1'b1; winLine = 3'd5;
    expectOut(S_RD, 8'h85, "R13 poll read wins");
    expectOut(S_ACKF, 8'h01, "R13 single ack");
    @(negedge clk);
    rdEn = 1'b0; intAck = 1'b0; winValid = 1'b0;
    expectOut(S_ISR, 8'h28, "R13 one line acknowledged");
    doRead(1'b1, 8'h3C, "R13 poll cleared after collision");

    @(negedge clk);
    #2;
    if (queueQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard not drained actual=%0d expected=0", queueQ.size());
    end
    finishRun();
  end
endmodule